// File: doc/BRIEF.md
# Indexed Configuration Window with Bus Port Router

This block gives a small power-management configuration space behind a two-byte I/O window. One byte of the window holds a pointer. The other byte reads or writes the configuration register that the pointer names. The space holds four registers:

- a 16-bit controller I/O base, whose low byte also carries the controller enable bit;
- a flag that advertises several switchable ports;
- a port-select register.

The port-select value steers a single shared SMBus host engine onto one of up to four physical clock/data pin pairs. It does this through open-drain pull-low enables and by returning the selected pair's input levels to the engine.

A parameter chooses between two encodings of the select value:

- **Legacy encoding.** The port number sits in bits [2:1] of the select register. It takes effect only when the multi-port flag is set.
- **Newer encoding.** The port number is bit 3 of a port-index register at a different pointer value. Only two ports exist in this encoding.

A port change requested while the engine reports busy is held back. It is applied once the engine is idle.

The window is driven by a byte-wide strobe interface. A read response comes back one cycle later with a valid pulse. The response cannot be stalled: there is no back-pressure, so the requester must take the byte in the cycle that valid is high.

Top module: `regwin_portmux`

## Requirements
- R1: After reset the pointer is 0x00, the base registers hold the parameter reset value (default base 0x0B00 with enable 1, so the low byte reads 0x01 and the high byte 0x0B), and the multi-port flag and select registers read 0x00.
- R2: A write with `win_addr`=0 loads the 8-bit pointer; a read with `win_addr`=0 returns the pointer.
- R3: Every read strobe produces `rd_valid` high in the next cycle only, with `rd_data` holding the addressed byte; a read with `win_addr`=1 returns the register named by the pointer.
- R4: Pointer 0x2C is the base low byte (bit 0 is the controller enable) and 0x2D the base high byte; `io_base` = {high byte, low byte with bit 0 forced to 0} and `ctl_enable` = low-byte bit 0, both updated the cycle after the write.
- R5: While `ctl_enable` is 0 every port pull-low enable is 0 and the engine sees both lines high.
- R6: Legacy encoding: the select register is at pointer 0x30, the port number is bits [2:1] and it is honoured only while bit 0 of the multi-port flag (pointer 0x2E) is 1; with the flag clear the engine is routed to port 0.
- R7: Newer encoding: the port-index register is at pointer 0x31, the port number is bit 3, at most two ports, the multi-port flag is ignored, and pointer 0x30 is unimplemented.
- R8: Writing 0x00 to the select register routes the engine to port 0.
- R9: A read of an unimplemented pointer returns 0x00 and a write to it changes no register and no routing.
- R10: A select write while `eng_busy` is 1 leaves routing unchanged; the new port takes effect at the first clock edge at which `eng_busy` is 0, and the latest such write wins.
- R11: Only the routed port drives the engine's pull-low enables, every other port's enables are 0, and the engine's input lines come from the routed port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_wr | input | 1 | Write strobe, one cycle |
| win_rd | input | 1 | Read strobe, one cycle |
| win_addr | input | 1 | Window offset: 0 pointer, 1 data |
| win_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Read response byte |
| rd_valid | output | 1 | Read response valid |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_scl_oe | input | 1 | Engine pulls clock low |
| eng_sda_oe | input | 1 | Engine pulls data low |
| eng_scl_in | output | 1 | Clock level seen by engine |
| eng_sda_in | output | 1 | Data level seen by engine |
| port_scl_oe | output | NUM_PORTS | Per-port clock pull-low enable |
| port_sda_oe | output | NUM_PORTS | Per-port data pull-low enable |
| port_scl_in | input | NUM_PORTS | Per-port clock level |
| port_sda_in | input | NUM_PORTS | Per-port data level |
| ctl_enable | output | 1 | Controller enable bit |
| io_base | output | 16 | Controller I/O base |

## Verification
Read data is due one cycle after its strobe, marked by `rd_valid`. Register writes, and the routing and base outputs that follow from them, are due one cycle after the write edge. A select change that was held back for busy is due one edge after `eng_busy` falls.

Inputs change on falling edges. A monitor on the falling edge pops the expected byte from a scoreboard queue whenever `rd_valid` is high. Routing and base checks are taken on the falling edge that follows the edge that should have updated them. The check made while busy is still high proves that nothing moved early.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int unsigned BYTE_W = 8;

  // window offsets
  localparam logic OFS_PTR  = 1'b0;
  localparam logic OFS_DATA = 1'b1;

  typedef struct packed {
    logic [BYTE_W-1:0] base_lo;
    logic [BYTE_W-1:0] base_hi;
    logic [BYTE_W-1:0] multi;
    logic [BYTE_W-1:0] psel;
  } cfg_regs_t;

  // legacy encoding: port number in bits [2:1]
  function automatic logic [1:0] legacy_port(input logic [BYTE_W-1:0] v);
    return v[2:1];
  endfunction

  // newer encoding: port number in bit 3, two ports only
  function automatic logic [1:0] newer_port(input logic [BYTE_W-1:0] v);
    return {1'b0, v[3]};
  endfunction
endpackage

// File: rtl/rw_ptr_decode.sv
module rw_ptr_decode
  import rw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_wr,
  input  logic              win_rd,
  input  logic              win_addr,
  input  logic [BYTE_W-1:0] win_wdata,
  output logic [BYTE_W-1:0] ptr_q,
  output logic              data_wr,
  output logic              data_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (win_wr && win_addr == OFS_PTR)
      ptr_q <= win_wdata;
  end

  assign data_wr = win_wr && (win_addr == OFS_DATA);
  assign data_rd = win_rd && (win_addr == OFS_DATA);
endmodule

// File: rtl/rw_cfg_store.sv
module rw_cfg_store
  import rw_pkg::*;
#(
  parameter logic [15:0]       RST_BASE   = 16'h0B00,
  parameter bit                RST_EN     = 1'b1,
  parameter logic [BYTE_W-1:0] IDX_BASE   = 8'h2C,
  parameter logic [BYTE_W-1:0] IDX_MULTI  = 8'h2E,
  parameter logic [BYTE_W-1:0] IDX_LSEL   = 8'h30,
  parameter logic [BYTE_W-1:0] IDX_NSEL   = 8'h31,
  parameter bit                NEW_LAYOUT = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ptr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_regs_t         regs,
  output logic              sel_wr,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam logic [BYTE_W-1:0] IDX_BASE_HI = IDX_BASE + 8'd1;
  localparam logic [BYTE_W-1:0] IDX_SEL     = NEW_LAYOUT ? IDX_NSEL : IDX_LSEL;
  localparam logic [BYTE_W-1:0] RST_LO      = {RST_BASE[7:1], RST_EN};

  logic hit_lo, hit_hi, hit_multi, hit_sel;

  assign hit_lo    = (ptr == IDX_BASE);
  assign hit_hi    = (ptr == IDX_BASE_HI);
  assign hit_multi = (ptr == IDX_MULTI);
  assign hit_sel   = (ptr == IDX_SEL);
  assign sel_wr    = data_wr && hit_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs.base_lo <= RST_LO;
      regs.base_hi <= RST_BASE[15:8];
      regs.multi   <= '0;
      regs.psel    <= '0;
    end else if (data_wr) begin
      if (hit_lo)    regs.base_lo <= wdata;
      if (hit_hi)    regs.base_hi <= wdata;
      if (hit_multi) regs.multi   <= wdata;
      if (hit_sel)   regs.psel    <= wdata;
    end
  end

  always_comb begin
    rd_byte = '0;
    if (hit_lo)    rd_byte = regs.base_lo;
    if (hit_hi)    rd_byte = regs.base_hi;
    if (hit_multi) rd_byte = regs.multi;
    if (hit_sel)   rd_byte = regs.psel;
  end
endmodule

// File: rtl/rw_port_router.sv
module rw_port_router
  import rw_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter bit          NEW_LAYOUT = 1'b0,
  parameter int unsigned PW         = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_wr,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 eng_busy,
  input  logic                 enable,
  input  logic                 multi_en,
  input  logic                 eng_scl_oe,
  input  logic                 eng_sda_oe,
  output logic                 eng_scl_in,
  output logic                 eng_sda_in,
  output logic [NUM_PORTS-1:0] port_scl_oe,
  output logic [NUM_PORTS-1:0] port_sda_oe,
  input  logic [NUM_PORTS-1:0] port_scl_in,
  input  logic [NUM_PORTS-1:0] port_sda_in,
  output logic [PW-1:0]        act_port
);
  logic [1:0]    raw;
  logic [PW-1:0] req_port;
  logic [PW-1:0] pend_port;
  logic          pend;
  logic [PW-1:0] route;

  generate
    if (NEW_LAYOUT) begin : g_newer
      assign raw = newer_port(wdata);
    end else begin : g_legacy
      assign raw = legacy_port(wdata);
    end
  endgenerate

  // out-of-range port numbers fall back to port 0
  assign req_port = (32'(raw) < NUM_PORTS) ? PW'(raw) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_port  <= '0;
      pend_port <= '0;
      pend      <= 1'b0;
    end else if (sel_wr && eng_busy) begin
      pend_port <= req_port;
      pend      <= 1'b1;
    end else if (sel_wr) begin
      act_port  <= req_port;
      pend      <= 1'b0;
    end else if (pend && !eng_busy) begin
      act_port  <= pend_port;
      pend      <= 1'b0;
    end
  end

  assign route = (!NEW_LAYOUT && !multi_en) ? '0 : act_port;

  always_comb begin
    port_scl_oe = '0;
    port_sda_oe = '0;
    eng_scl_in  = 1'b1;
    eng_sda_in  = 1'b1;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (enable && route == PW'(i)) begin
        port_scl_oe[i] = eng_scl_oe;
        port_sda_oe[i] = eng_sda_oe;
        eng_scl_in     = port_scl_in[i];
        eng_sda_in     = port_sda_in[i];
      end
    end
  end
endmodule

// File: rtl/regwin_portmux.sv
module regwin_portmux
  import rw_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter bit          NEW_LAYOUT = 1'b0,
  parameter logic [15:0] RST_BASE   = 16'h0B00,
  parameter bit          RST_EN     = 1'b1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_wr,
  input  logic                 win_rd,
  input  logic                 win_addr,
  input  logic [7:0]           win_wdata,
  output logic [7:0]           rd_data,
  output logic                 rd_valid,
  input  logic                 eng_busy,
  input  logic                 eng_scl_oe,
  input  logic                 eng_sda_oe,
  output logic                 eng_scl_in,
  output logic                 eng_sda_in,
  output logic [NUM_PORTS-1:0] port_scl_oe,
  output logic [NUM_PORTS-1:0] port_sda_oe,
  input  logic [NUM_PORTS-1:0] port_scl_in,
  input  logic [NUM_PORTS-1:0] port_sda_in,
  output logic                 ctl_enable,
  output logic [15:0]          io_base
);
  localparam int unsigned PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [BYTE_W-1:0] ptr_q;
  logic              data_wr;
  logic              data_rd;
  cfg_regs_t         regs;
  logic              sel_wr;
  logic [BYTE_W-1:0] store_byte;
  logic [PW-1:0]     act_port;

  rw_ptr_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .win_wr(win_wr), .win_rd(win_rd), .win_addr(win_addr), .win_wdata(win_wdata),
    .ptr_q(ptr_q), .data_wr(data_wr), .data_rd(data_rd)
  );

  rw_cfg_store #(
    .RST_BASE(RST_BASE), .RST_EN(RST_EN), .NEW_LAYOUT(NEW_LAYOUT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ptr(ptr_q), .data_wr(data_wr), .wdata(win_wdata),
    .regs(regs), .sel_wr(sel_wr), .rd_byte(store_byte)
  );

  rw_port_router #(
    .NUM_PORTS(NUM_PORTS), .NEW_LAYOUT(NEW_LAYOUT), .PW(PW)
  ) u_route (
    .clk(clk), .rst_n(rst_n),
    .sel_wr(sel_wr), .wdata(win_wdata), .eng_busy(eng_busy),
    .enable(ctl_enable), .multi_en(regs.multi[0]),
    .eng_scl_oe(eng_scl_oe), .eng_sda_oe(eng_sda_oe),
    .eng_scl_in(eng_scl_in), .eng_sda_in(eng_sda_in),
    .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
    .port_scl_in(port_scl_in), .port_sda_in(port_sda_in),
    .act_port(act_port)
  );

  assign ctl_enable = regs.base_lo[0];
  assign io_base    = {regs.base_hi, regs.base_lo[7:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= win_rd;
      if (data_rd)
        rd_data <= store_byte;
      else if (win_rd)
        rd_data <= ptr_q;
    end
  end
endmodule

// File: rtl/rw_portmux_chk.sv
module rw_portmux_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PW        = 2
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 win_wr,
  input logic                 win_rd,
  input logic                 rd_valid,
  input logic                 eng_busy,
  input logic                 ctl_enable,
  input logic [15:0]          io_base,
  input logic [NUM_PORTS-1:0] port_scl_oe,
  input logic [NUM_PORTS-1:0] port_sda_oe,
  input logic [PW-1:0]        act_port
);
  p_valid_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |=> rd_valid);

  p_no_valid_unasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_rd |=> !rd_valid);

  p_released_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> (port_scl_oe == '0 && port_sda_oe == '0));

  p_single_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_scl_oe) && $onehot0(port_sda_oe));

  p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_busy) |-> $stable(act_port));

  p_cfg_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> ($stable(io_base) && $stable(ctl_enable)));
endmodule

bind regwin_portmux rw_portmux_chk #(
  .NUM_PORTS(NUM_PORTS), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_rd(win_rd),
  .rd_valid(rd_valid), .eng_busy(eng_busy), .ctl_enable(ctl_enable),
  .io_base(io_base), .port_scl_oe(port_scl_oe), .port_sda_oe(port_sda_oe),
  .act_port(act_port)
);

// File: tb/sim_regwin_portmux.sv
module sim_regwin_portmux;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // two instances: index 0 legacy encoding, index 1 newer encoding
  logic       wr [2];
  logic       rd [2];
  logic       ad [2];
  logic [7:0] wd [2];
  logic [7:0] rdat [2];
  logic       rv [2];
  logic       busy [2];
  logic       e_scl_oe [2];
  logic       e_sda_oe [2];
  logic       e_scl_in [2];
  logic       e_sda_in [2];
  logic [3:0] p_scl_oe [2];
  logic [3:0] p_sda_oe [2];
  logic [3:0] p_scl_in [2];
  logic [3:0] p_sda_in [2];
  logic       en [2];
  logic [15:0] base [2];

  regwin_portmux #(.NEW_LAYOUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .win_wr(wr[0]), .win_rd(rd[0]), .win_addr(ad[0]),
    .win_wdata(wd[0]), .rd_data(rdat[0]), .rd_valid(rv[0]), .eng_busy(busy[0]),
    .eng_scl_oe(e_scl_oe[0]), .eng_sda_oe(e_sda_oe[0]),
    .eng_scl_in(e_scl_in[0]), .eng_sda_in(e_sda_in[0]),
    .port_scl_oe(p_scl_oe[0]), .port_sda_oe(p_sda_oe[0]),
    .port_scl_in(p_scl_in[0]), .port_sda_in(p_sda_in[0]),
    .ctl_enable(en[0]), .io_base(base[0])
  );

  regwin_portmux #(.NEW_LAYOUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .win_wr(wr[1]), .win_rd(rd[1]), .win_addr(ad[1]),
    .win_wdata(wd[1]), .rd_data(rdat[1]), .rd_valid(rv[1]), .eng_busy(busy[1]),
    .eng_scl_oe(e_scl_oe[1]), .eng_sda_oe(e_sda_oe[1]),
    .eng_scl_in(e_scl_in[1]), .eng_sda_in(e_sda_in[1]),
    .port_scl_oe(p_scl_oe[1]), .port_sda_oe(p_sda_oe[1]),
    .port_scl_in(p_scl_in[1]), .port_sda_in(p_sda_in[1]),
    .ctl_enable(en[1]), .io_base(base[1])
  );

  logic [7:0] exp_q0 [$];
  string      req_q0 [$];
  logic [7:0] exp_q1 [$];
  string      req_q1 [$];

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int w, input logic a, input logic [7:0] d);
    @(negedge clk);
    wr[w] = 1'b1; ad[w] = a; wd[w] = d;
    @(negedge clk);
    wr[w] = 1'b0;
  endtask

  task automatic bus_read(input int w, input logic a, input logic [7:0] e, input string req);
    @(negedge clk);
    if (w == 0) begin exp_q0.push_back(e); req_q0.push_back(req); end
    else        begin exp_q1.push_back(e); req_q1.push_back(req); end
    rd[w] = 1'b1; ad[w] = a;
    @(negedge clk);
    rd[w] = 1'b0;
  endtask

  task automatic reg_write(input int w, input logic [7:0] idx, input logic [7:0] d);
    bus_write(w, 1'b0, idx);
    bus_write(w, 1'b1, d);
  endtask

  task automatic reg_read(input int w, input logic [7:0] idx, input logic [7:0] e, input string req);
    bus_write(w, 1'b0, idx);
    bus_read(w, 1'b1, e, req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rv[0]) begin
      if (exp_q0.size() == 0) check("R3 unexpected valid u0", 16'h1, 16'h0);
      else check(req_q0.pop_front(), {8'h0, rdat[0]}, {8'h0, exp_q0.pop_front()});
    end
    if (rst_n && rv[1]) begin
      if (exp_q1.size() == 0) check("R3 unexpected valid u1", 16'h1, 16'h0);
      else check(req_q1.pop_front(), {8'h0, rdat[1]}, {8'h0, exp_q1.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      wr[i] = 0; rd[i] = 0; ad[i] = 0; wd[i] = 0; busy[i] = 0;
      e_scl_oe[i] = 1'b1; e_sda_oe[i] = 1'b0;
      p_scl_in[i] = 4'hF; p_sda_in[i] = 4'hF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 io_base", base[0], 16'h0B00);
    check("R1 ctl_enable", {15'h0, en[0]}, 16'h1);
    check("R11 reset route port0", {12'h0, p_scl_oe[0]}, 16'h0001);
    bus_read(0, 1'b0, 8'h00, "R1 R2 pointer after reset");
    bus_read(0, 1'b1, 8'h00, "R9 unimplemented pointer 0");
    reg_read(0, 8'h2C, 8'h01, "R1 R3 base low");
    bus_read(0, 1'b0, 8'h2C, "R2 pointer readback");
    reg_read(0, 8'h2D, 8'h0B, "R1 base high");
    reg_read(0, 8'h2E, 8'h00, "R1 multi flag");

    // R4 base rewrite
    reg_write(0, 8'h2D, 8'hC5);
    reg_write(0, 8'h2C, 8'h41);
    check("R4 io_base", base[0], 16'hC540);
    check("R4 ctl_enable", {15'h0, en[0]}, 16'h1);

    // R6 flag clear keeps port 0
    reg_write(0, 8'h30, 8'h06);
    check("R6 flag clear port0", {12'h0, p_scl_oe[0]}, 16'h0001);
    reg_read(0, 8'h30, 8'h06, "R3 select readback");
    reg_write(0, 8'h2E, 8'h01);
    check("R6 port3 route", {12'h0, p_scl_oe[0]}, 16'h0008);
    p_sda_in[0] = 4'b0111;
    #1;
    check("R11 engine data from port3", {15'h0, e_sda_in[0]}, 16'h0);
    check("R11 data enables idle", {12'h0, p_sda_oe[0]}, 16'h0000);
    p_sda_in[0] = 4'hF;
    reg_write(0, 8'h30, 8'h02);
    check("R6 port1 route", {12'h0, p_scl_oe[0]}, 16'h0002);

    // R10 busy hold-off
    bus_write(0, 1'b0, 8'h30);
    busy[0] = 1'b1;
    bus_write(0, 1'b1, 8'h04);
    check("R10 held while busy", {12'h0, p_scl_oe[0]}, 16'h0002);
    @(negedge clk);
    check("R10 still held", {12'h0, p_scl_oe[0]}, 16'h0002);
    busy[0] = 1'b0;
    @(negedge clk);
    check("R10 applied after idle", {12'h0, p_scl_oe[0]}, 16'h0004);

    // R8 back to port 0
    bus_write(0, 1'b1, 8'h00);
    check("R8 zero routes port0", {12'h0, p_scl_oe[0]}, 16'h0001);

    // R9 unimplemented write ignored
    reg_write(0, 8'h10, 8'hFF);
    bus_read(0, 1'b1, 8'h00, "R9 unimplemented read");
    check("R9 route unchanged", {12'h0, p_scl_oe[0]}, 16'h0001);
    check("R9 base unchanged", base[0], 16'hC540);
    reg_read(0, 8'h2E, 8'h01, "R9 flag unchanged");

    // R5 disable
    p_scl_in[0] = 4'h0;
    reg_write(0, 8'h2C, 8'h40);
    check("R5 enable clear", {15'h0, en[0]}, 16'h0);
    check("R5 all released", {8'h0, p_scl_oe[0], p_sda_oe[0]}, 16'h0000);
    check("R5 engine sees high", {15'h0, e_scl_in[0]}, 16'h1);

    // R7 newer encoding on u1
    reg_write(1, 8'h31, 8'h08);
    check("R7 newer port1", {12'h0, p_scl_oe[1]}, 16'h0002);
    reg_write(1, 8'h30, 8'h06);
    bus_read(1, 1'b1, 8'h00, "R7 R9 legacy pointer unimplemented");
    check("R7 route unchanged", {12'h0, p_scl_oe[1]}, 16'h0002);
    reg_write(1, 8'h31, 8'h00);
    check("R8 newer zero port0", {12'h0, p_scl_oe[1]}, 16'h0001);

    repeat (3) @(negedge clk);
    check("R3 all reads answered", 16'(exp_q0.size() + exp_q1.size()), 16'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule